// File: doc/BRIEF.md
# Serial Port Modem Loopback Path

This block is the self-test loopback stage of a serial port. While software holds the loop-enable bit of the port's control word set, the block does three things. It turns the four software-driven modem-control outputs back into the four modem-status flags. It copies every transmitted character into the receive queue. It turns a newly raised send-break request into a marked receive word. Characters that arrive from the external line are dropped while loopback is active.

With loopback cleared, the modem-status flags track the external modem pins through a synchroniser, and external receive characters pass straight through to the receive queue. Every control write that leaves loopback enabled refreshes the whole modem-status interrupt group. The block drives a clear strobe for the four raw modem interrupt bits, together with a set vector that carries the looped levels, so the interrupt register beside it rebuilds the group in a single cycle.

Top module: `modem_loop_top`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `flags`, `rxq_push`, `ms_irq_clr` and `ms_irq_set` are all zero.
- R2: Control-word fields are loop-enable = bit 0, dtr = bit 1, rts = bit 2, out1 = bit 3 and out2 = bit 4. Flag bits are dsr = bit 0, cts = bit 1, dcd = bit 2 and ri = bit 3. A control write with loop-enable set makes ri = out2, dcd = out1, cts = rts and dsr = dtr, visible on `flags` in the cycle after the write.
- R3: The crossing of R2 also happens on a write that only turns loop-enable on, coming from the loopback-off state.
- R4: In the cycle after every control write with loop-enable set, `ms_irq_clr` is 1 and `ms_irq_set` equals the newly looped flag levels. In every other cycle both are zero, including after a write that clears loop-enable.
- R5: With loopback on, a transmit write while `rxq_ready` is 1 pushes {zeros, data} in the next cycle. When `rxq_ready` is 0, the looped character is not pushed.
- R6: With loopback on, an external receive push produces no push on `rxq_push`.
- R7: With loopback off, an external receive push is forwarded as {zeros, data} in the next cycle, and transmit writes push nothing.
- R8: With loopback on, a 0-to-1 change of `brk_req` pushes a word that has only bit BRK_POS (default 10) set. A held or falling `brk_req` pushes nothing, and a rise with loopback off pushes nothing.
- R9: When a looped transmit push and a break rise fall in the same cycle, the transmit word is pushed first and the break word follows in the next free cycle. Neither is lost.
- R10: With loopback off, `flags` follows `modem_in` (same bit order as `flags`) after synchronisation. With loopback on, `modem_in` has no effect on `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 5 | Control word being written |
| tx_wr | input | 1 | Transmit-data write strobe |
| tx_data | input | DATA_W | Transmit character |
| brk_req | input | 1 | Send-break level from the line-control register |
| ext_rx_valid | input | 1 | External receive character valid |
| ext_rx_data | input | DATA_W | External receive character |
| modem_in | input | 4 | External modem status pins {ri, dcd, cts, dsr} |
| rxq_ready | input | 1 | Receive queue can accept a word |
| flags | output | 4 | Modem status flags {ri, dcd, cts, dsr} |
| rxq_push | output | 1 | Push strobe to the receive queue |
| rxq_word | output | BRK_POS+1 | Word pushed to the receive queue |
| ms_irq_clr | output | 1 | Clear all four modem raw interrupt bits |
| ms_irq_set | output | 4 | Modem raw interrupt bits to set after the clear |

## Verification
The two functions that can collide are the looped transmit push and the break push, because both need the single receive-queue port. The bench raises `brk_req` on the same clock edge as a transmit write. The scoreboard then requires the transmit word first, the marked break word exactly one cycle later, and no further words after them. A second kind of overlap, an external character arriving during loopback, is judged by requiring that nothing reaches the queue at all.

// File: rtl/mloop_pkg.sv
package mloop_pkg;
  // control word field positions
  localparam int CTL_W    = 5;
  localparam int CTL_LOOP = 0;
  localparam int CTL_DTR  = 1;
  localparam int CTL_RTS  = 2;
  localparam int CTL_OUT1 = 3;
  localparam int CTL_OUT2 = 4;
  // modem flag positions
  localparam int NMODEM   = 4;
  localparam int FLG_DSR  = 0;
  localparam int FLG_CTS  = 1;
  localparam int FLG_DCD  = 2;
  localparam int FLG_RI   = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TX   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_BRK  = 2'd3
  } push_src_e;

  function automatic logic [NMODEM-1:0] cross_lines(input logic [CTL_W-1:0] c);
    logic [NMODEM-1:0] f;
    f          = '0;
    f[FLG_RI]  = c[CTL_OUT2];
    f[FLG_DCD] = c[CTL_OUT1];
    f[FLG_CTS] = c[CTL_RTS];
    f[FLG_DSR] = c[CTL_DTR];
    return f;
  endfunction
endpackage

// File: rtl/mloop_rst_sync.sv
module mloop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mloop_ctl_reg.sv
module mloop_ctl_reg
  import mloop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              loop_q,
  output logic              cross_fire,
  output logic [NMODEM-1:0] cross_lvl
);
  logic loop_d;
  logic loop_en;

  // the enable bit is only loaded on a control write
  assign loop_en = ctl_wr;

  always_comb begin
    loop_d     = ctl_wdata[CTL_LOOP];
    cross_fire = ctl_wr & ctl_wdata[CTL_LOOP];
    cross_lvl  = cross_lines(ctl_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       loop_q <= 1'b0;
    else if (loop_en) loop_q <= loop_d;
  end

  // R3: entering loopback from off also fires the crossing
  p_enter_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CTL_LOOP] && !loop_q) |=> loop_q);
endmodule

// File: rtl/mloop_flag_path.sv
module mloop_flag_path
  import mloop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMODEM-1:0] modem_in,
  input  logic              loop_q,
  input  logic              cross_fire,
  input  logic [NMODEM-1:0] cross_lvl,
  output logic [NMODEM-1:0] flags,
  output logic              ms_irq_clr,
  output logic [NMODEM-1:0] ms_irq_set
);
  logic [NMODEM-1:0] sync_q [SYNC_STAGES];
  logic [NMODEM-1:0] flags_d;
  logic              clr_d;
  logic [NMODEM-1:0] set_d;

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      logic [NMODEM-1:0] stage_d;
      if (gs == 0) begin : g_first
        assign stage_d = modem_in;
      end else begin : g_rest
        assign stage_d = sync_q[gs-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[gs] <= '0;
        else        sync_q[gs] <= stage_d;
      end
    end
  endgenerate

  always_comb begin
    if (cross_fire)  flags_d = cross_lvl;
    else if (loop_q) flags_d = flags;
    else             flags_d = sync_q[SYNC_STAGES-1];
    clr_d = cross_fire;
    set_d = cross_fire ? cross_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      ms_irq_clr <= 1'b0;
      ms_irq_set <= '0;
    end else begin
      flags      <= flags_d;
      ms_irq_clr <= clr_d;
      ms_irq_set <= set_d;
    end
  end

  // R2: crossing result is on the flags one cycle after the write
  p_cross_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cross_fire |=> (flags == $past(cross_lvl)));
  // R4: a set vector never appears without the group clear
  p_set_needs_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_irq_set != '0) |-> ms_irq_clr);
  // R4: the set vector mirrors the looped flags
  p_set_is_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_irq_clr |-> (ms_irq_set == flags));
  // R10: pins are ignored while looping without writes
  p_loop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !cross_fire) |=> $stable(flags));
endmodule

// File: rtl/mloop_rx_mux.sv
module mloop_rx_mux
  import mloop_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BRK_POS = 10,
  localparam int WORD_W = BRK_POS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_q,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              brk_req,
  input  logic              ext_rx_valid,
  input  logic [DATA_W-1:0] ext_rx_data,
  input  logic              rxq_ready,
  output logic              rxq_push,
  output logic [WORD_W-1:0] rxq_word
);
  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_POS;

  logic        brk_d_q;
  logic        brk_pend_q;
  logic        brk_pend_d;
  logic        brk_rise;
  logic        brk_want;
  logic        tx_take;
  logic        ext_take;
  push_src_e   src;
  logic        push_d;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    brk_rise = loop_q & brk_req & ~brk_d_q;
    tx_take  = loop_q & tx_wr & rxq_ready;
    ext_take = ~loop_q & ext_rx_valid;
    brk_want = brk_rise | brk_pend_q;
    if (tx_take)       src = SRC_TX;
    else if (ext_take) src = SRC_EXT;
    else if (brk_want) src = SRC_BRK;
    else               src = SRC_NONE;
    brk_pend_d = brk_want & (src != SRC_BRK);
    push_d     = (src != SRC_NONE);
    case (src)
      SRC_TX:  word_d = WORD_W'(tx_data);
      SRC_EXT: word_d = WORD_W'(ext_rx_data);
      SRC_BRK: word_d = BRK_WORD;
      default: word_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_d_q    <= 1'b0;
      brk_pend_q <= 1'b0;
      rxq_push   <= 1'b0;
      rxq_word   <= '0;
    end else begin
      brk_d_q    <= brk_req;
      brk_pend_q <= brk_pend_d;
      rxq_push   <= push_d;
      if (push_d) rxq_word <= word_d;
    end
  end

  // R5: a looped char refused by the queue yields no data push
  p_no_push_unready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && tx_wr && !rxq_ready) |=> (!rxq_push || rxq_word[BRK_POS]));
  // R6: with loopback on only looped traffic reaches the queue
  p_ext_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !tx_wr) |=> (!rxq_push || rxq_word[BRK_POS]));
  // R8: a break word carries no data bits
  p_brk_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_push && rxq_word[BRK_POS]) |-> (rxq_word[BRK_POS-1:0] == '0));
  // R9: a deferred break is pushed once the slot frees
  p_pend_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend_q && !tx_take && !ext_take) |=> (rxq_push && rxq_word[BRK_POS]));
endmodule

// File: rtl/modem_loop_top.sv
module modem_loop_top
  import mloop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BRK_POS     = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [4:0]           ctl_wdata,
  input  logic                 tx_wr,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 brk_req,
  input  logic                 ext_rx_valid,
  input  logic [DATA_W-1:0]    ext_rx_data,
  input  logic [3:0]           modem_in,
  input  logic                 rxq_ready,
  output logic [3:0]           flags,
  output logic                 rxq_push,
  output logic [BRK_POS:0]     rxq_word,
  output logic                 ms_irq_clr,
  output logic [3:0]           ms_irq_set
);
  logic              rst_int_n;
  logic              loop_q;
  logic              cross_fire;
  logic [NMODEM-1:0] cross_lvl;

  mloop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  mloop_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .loop_q(loop_q), .cross_fire(cross_fire), .cross_lvl(cross_lvl)
  );

  mloop_flag_path #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk(clk), .rst_n(rst_int_n), .modem_in(modem_in),
    .loop_q(loop_q), .cross_fire(cross_fire), .cross_lvl(cross_lvl),
    .flags(flags), .ms_irq_clr(ms_irq_clr), .ms_irq_set(ms_irq_set)
  );

  mloop_rx_mux #(.DATA_W(DATA_W), .BRK_POS(BRK_POS)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .loop_q(loop_q),
    .tx_wr(tx_wr), .tx_data(tx_data), .brk_req(brk_req),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
    .rxq_ready(rxq_ready), .rxq_push(rxq_push), .rxq_word(rxq_word)
  );

  // R1: nothing leaves the block while reset is held internally
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |=> (!rxq_push && !ms_irq_clr && flags == '0));
endmodule

// File: tb/tb_modem_loop_top.sv
module tb_modem_loop_top;
  localparam int DW = 8;
  localparam int BP = 10;
  localparam int WW = BP + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_wr;
  logic [4:0]    ctl_wdata;
  logic          tx_wr;
  logic [DW-1:0] tx_data;
  logic          brk_req;
  logic          ext_rx_valid;
  logic [DW-1:0] ext_rx_data;
  logic [3:0]    modem_in;
  logic          rxq_ready;
  logic [3:0]    flags;
  logic          rxq_push;
  logic [WW-1:0] rxq_word;
  logic          ms_irq_clr;
  logic [3:0]    ms_irq_set;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [WW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  modem_loop_top dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tx_wr(tx_wr), .tx_data(tx_data), .brk_req(brk_req),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
    .modem_in(modem_in), .rxq_ready(rxq_ready), .flags(flags),
    .rxq_push(rxq_push), .rxq_word(rxq_word),
    .ms_irq_clr(ms_irq_clr), .ms_irq_set(ms_irq_set)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected words as pushes appear
  always @(negedge clk) begin
    if (rst_n && !done && rxq_push) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R5-R9 unexpected push actual=%0h expected=none", rxq_word);
      end else begin
        logic [WW-1:0] e;
        e = exp_q.pop_front();
        if (rxq_word !== e) begin
          failures++;
          $display("FAIL R5-R9 word actual=%0h expected=%0h", rxq_word, e);
        end
      end
    end
  end

  task automatic ctl_write(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic tx_send(input logic [DW-1:0] d, input bit expect_push);
    if (expect_push) exp_q.push_back(WW'(d));
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic ext_send(input logic [DW-1:0] d, input bit expect_push);
    if (expect_push) exp_q.push_back(WW'(d));
    ext_rx_valid = 1'b1; ext_rx_data = d;
    @(negedge clk);
    ext_rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; tx_wr = 1'b0; tx_data = '0;
    brk_req = 1'b0; ext_rx_valid = 1'b0; ext_rx_data = '0;
    modem_in = 4'b0000; rxq_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", flags, 0);
    check("R1 push in reset", rxq_push, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flags after reset", flags, 0);
    check("R1 clr after reset", ms_irq_clr, 0);

    // R10: loopback off, flags follow pins
    modem_in = 4'b1010;
    repeat (5) @(negedge clk);
    check("R10 flags follow pins", flags, 4'b1010);

    // R7: pass-through with loopback off
    ext_send(8'h5A, 1'b1);
    tx_send(8'h11, 1'b0);
    check("R7 tx not pushed when loop off", rxq_push, 0);

    // R3/R4: write that only sets loop-enable
    ctl_write(5'b00001);
    check("R3 flags cross on loop-only write", flags, 4'b0000);
    check("R4 clr on loop-only write", ms_irq_clr, 1);
    check("R4 set on loop-only write", ms_irq_set, 4'b0000);
    @(negedge clk);
    check("R4 clr is one cycle", ms_irq_clr, 0);
    check("R10 pins ignored in loop", flags, 4'b0000);

    // R2/R4: out2 + dtr -> ri + dsr
    ctl_write(5'b10011);
    check("R2 out2/dtr crossing", flags, 4'b1001);
    check("R4 set out2/dtr", ms_irq_set, 4'b1001);
    ctl_write(5'b01101);
    check("R2 out1/rts crossing", flags, 4'b0110);
    check("R4 set out1/rts", ms_irq_set, 4'b0110);
    check("R4 clr strobe", ms_irq_clr, 1);

    // R5: looped transmit
    tx_send(8'hA5, 1'b1);
    tx_send(8'h3C, 1'b1);
    // R6: external input blocked
    ext_send(8'hEE, 1'b0);
    check("R6 ext blocked in loop", rxq_push, 0);
    // R5: queue not ready
    rxq_ready = 1'b0;
    tx_send(8'h99, 1'b0);
    check("R5 no push when not ready", rxq_push, 0);
    rxq_ready = 1'b1;

    // R8: break rise pushes marked word once
    exp_q.push_back(WW'(1) << BP);
    brk_req = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 held break no push", rxq_push, 0);
    brk_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 falling break no push", rxq_push, 0);

    // R9: same-cycle transmit and break
    exp_q.push_back(WW'(8'h77));
    exp_q.push_back(WW'(1) << BP);
    tx_wr = 1'b1; tx_data = 8'h77; brk_req = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    check("R9 tx word first", rxq_word, WW'(8'h77));
    @(negedge clk);
    check("R9 break word next", rxq_word, WW'(1) << BP);
    @(negedge clk);
    check("R9 nothing after", rxq_push, 0);
    brk_req = 1'b0;
    @(negedge clk);

    // leave loopback
    ctl_write(5'b11110);
    check("R4 no clr when loop off", ms_irq_clr, 0);
    modem_in = 4'b0101;
    repeat (5) @(negedge clk);
    check("R10 flags follow pins after loop off", flags, 4'b0101);
    brk_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 break ignored loop off", rxq_push, 0);
    brk_req = 1'b0;
    repeat (3) @(negedge clk);

    check("R5-R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule